// File: doc/BRIEF.md
# Receive Flow-Control and Special Character Screen

This block sits between a UART receiver and its receive FIFO. For every received character, signalled by a one-cycle strobe, it makes three decisions. It decides whether the character is pushed into the FIFO. It decides whether the character is an in-band pause or resume request for the local transmitter. It decides whether the character matches a programmable special character. The special character has no register of its own. It reuses the second pause register. The flow-control mode then decides whether a matching byte is kept as data or consumed as a control character.

Two pause/resume character pairs are held in registers. A two-bit mode selects which pair is active, or disables in-band flow control. Recognised pause and resume characters are removed from the data stream. A recognised pause character raises a one-cycle pause interrupt and sets a level that holds the transmitter. A special-character hit sets a sticky status flag, which the interrupt-status read clears. It also raises a one-cycle interrupt when that interrupt is enabled.

Top module: `rxc_screen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fifo_we`, `xoff_irq`, `spc_irq`, `spc_flag` and `tx_paused` are all 0. Asserting reset clears a set `tx_paused` at once.
- R2: With `fc_mode` 2'b00 or 2'b11, in-band flow control is off. Every strobed byte is written to the FIFO, `xoff_irq` stays 0, and `tx_paused` keeps its value.
- R3: With `fc_mode` 2'b10, a byte equal to `pause_char_a` is not written and pulses `xoff_irq`, and `tx_paused` becomes 1. A byte equal to `resume_char_a` is not written and clears `tx_paused`. Any other byte is written.
- R4: With `fc_mode` 2'b01, the same rules apply to `pause_char_b` and `resume_char_b`.
- R5: With `spc_en` 0, no byte sets `spc_flag` or pulses `spc_irq`.
- R6: With `spc_en` 1, every bit of a byte equal to `pause_char_b` sets `spc_flag`. Bit 0 of the register is compared with bit 0 of the byte. Unless the byte is also an active flow-control character, it is written to the FIFO. A byte that differs in any single bit does not match.
- R7: With `fc_mode` 2'b01 and `spc_en` 1, a byte equal to `pause_char_b` is dropped. It pulses `xoff_irq`, and it also pulses `spc_irq` when `spc_irq_en` is 1.
- R8: `spc_irq` pulses on a special-character hit only when `spc_irq_en` is 1. `spc_flag` is set whatever the value of `spc_irq_en`.
- R9: `spc_flag` stays 1 until an `isr_read` pulse. A hit in the same cycle as `isr_read` leaves the flag at 1.
- R10: With `OUT_REG`=1, the outputs for a byte strobed in cycle t appear in cycle t+1 and last one cycle. `fifo_wdata` carries that byte.
- R11: If the active pause and resume characters are equal, the byte is treated as a pause.
- R12: Without `rx_valid`, no output pulses and no state changes, whatever `rx_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | input | DW | Received character |
| pause_char_a | input | DW | Pause character of pair A |
| resume_char_a | input | DW | Resume character of pair A |
| pause_char_b | input | DW | Pause character of pair B, also the special character |
| resume_char_b | input | DW | Resume character of pair B |
| fc_mode | input | 2 | 2'b10 pair A, 2'b01 pair B, otherwise flow control off |
| spc_en | input | 1 | Special-character detect enable |
| spc_irq_en | input | 1 | Special-character interrupt enable |
| isr_read | input | 1 | Interrupt-status read pulse, clears `spc_flag` |
| fifo_we | output | 1 | Write enable to the receive FIFO |
| fifo_wdata | output | DW | Byte to write |
| xoff_irq | output | 1 | Pause-character interrupt pulse |
| spc_irq | output | 1 | Special-character interrupt pulse |
| spc_flag | output | 1 | Sticky special-character status |
| tx_paused | output | 1 | Transmitter hold requested by the far end |

## Verification
The bench builds the block with `DW`=8 and `OUT_REG`=1. This makes every decision visible exactly one cycle after its strobe. It also lets the bench confirm that nothing is asserted in the strobe cycle itself. Eight-bit characters make the bit-0 alignment check against `pause_char_b` meaningful with a pair of bytes that differ only in the LSB. The two pairs are set to distinct values, which exposes any mix-up between pair A and pair B. A temporary equal pause/resume setting reaches the priority corner.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

   localparam int NUM_PAIRS = 2;

   typedef enum logic [1:0] {
      FC_OFF    = 2'b00,
      FC_PAIR_B = 2'b01,
      FC_PAIR_A = 2'b10,
      FC_OFF_HI = 2'b11
   } fc_mode_e;

   typedef struct packed {
      logic store;
      logic pause;
      logic resume;
      logic spc;
   } verdict_t;

endpackage

// File: rtl/rxc_classify.sv
module rxc_classify
   import rxc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0]                 rx_data_i,
   input  logic [NUM_PAIRS-1:0][DW-1:0]  pause_chars_i,
   input  logic [NUM_PAIRS-1:0][DW-1:0]  resume_chars_i,
   input  logic [DW-1:0]                 spc_char_i,
   input  logic [1:0]                    mode_i,
   input  logic                          spc_en_i,
   output verdict_t                      verdict_o
);

   logic [NUM_PAIRS-1:0] pair_en;
   logic [NUM_PAIRS-1:0] pause_hit;
   logic [NUM_PAIRS-1:0] resume_hit;

   always_comb begin
      pair_en = '0;
      case (fc_mode_e'(mode_i))
         FC_PAIR_A: pair_en[0] = 1'b1;
         FC_PAIR_B: pair_en[1] = 1'b1;
         default:   pair_en    = '0;
      endcase
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign pause_hit[p]  = pair_en[p] && (rx_data_i == pause_chars_i[p]);
      assign resume_hit[p] = pair_en[p] && (rx_data_i == resume_chars_i[p]);
   end

   always_comb begin
      verdict_o.pause  = |pause_hit;
      verdict_o.resume = (|resume_hit) && !(|pause_hit);
      verdict_o.spc    = spc_en_i && (rx_data_i == spc_char_i);
      verdict_o.store  = !((|pause_hit) || (|resume_hit));
   end

endmodule

// File: rtl/rxc_stage.sv
module rxc_stage
   import rxc_pkg::*;
#(
   parameter int DW      = 8,
   parameter int OUT_REG = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [DW-1:0] data_i,
   input  verdict_t      verdict_i,
   input  logic          irq_en_i,
   output logic          fifo_we_o,
   output logic [DW-1:0] fifo_wdata_o,
   output logic          xoff_irq_o,
   output logic          spc_irq_o
);

   logic we_d, xoff_d, sirq_d;

   assign we_d   = vld_i && verdict_i.store;
   assign xoff_d = vld_i && verdict_i.pause;
   assign sirq_d = vld_i && verdict_i.spc && irq_en_i;

   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fifo_we_o    <= 1'b0;
            fifo_wdata_o <= '0;
            xoff_irq_o   <= 1'b0;
            spc_irq_o    <= 1'b0;
         end else begin
            fifo_we_o    <= we_d;
            fifo_wdata_o <= data_i;
            xoff_irq_o   <= xoff_d;
            spc_irq_o    <= sirq_d;
         end
      end

      AST_WE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_we_o |-> $past(vld_i)); // R12
   end else begin : g_comb
      assign fifo_we_o    = we_d;
      assign fifo_wdata_o = data_i;
      assign xoff_irq_o   = xoff_d;
      assign spc_irq_o    = sirq_d;
   end

   AST_PAUSE_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_irq_o |-> !fifo_we_o); // R3

endmodule

// File: rtl/rxc_flow_state.sv
module rxc_flow_state (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic paused_o
);

   logic paused_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     paused_q <= 1'b0;
      else if (set_i) paused_q <= 1'b1;
      else if (clr_i) paused_q <= 1'b0;
   end

   assign paused_o = paused_q;

   AST_PAUSE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused_q) |-> $past(set_i)); // R3
   AST_RESUME_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(paused_q) |-> $past(clr_i)); // R4

endmodule

// File: rtl/rxc_spc_status.sv
module rxc_spc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i && !set_i) |=> flag_q); // R9
   AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q); // R9

endmodule

// File: rtl/rxc_screen.sv
module rxc_screen
   import rxc_pkg::*;
#(
   parameter int DW      = 8,
   parameter int OUT_REG = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic [DW-1:0] pause_char_a,
   input  logic [DW-1:0] resume_char_a,
   input  logic [DW-1:0] pause_char_b,
   input  logic [DW-1:0] resume_char_b,
   input  logic [1:0]    fc_mode,
   input  logic          spc_en,
   input  logic          spc_irq_en,
   input  logic          isr_read,
   output logic          fifo_we,
   output logic [DW-1:0] fifo_wdata,
   output logic          xoff_irq,
   output logic          spc_irq,
   output logic          spc_flag,
   output logic          tx_paused
);

   if (DW < 5 || DW > 16) begin : g_bad_dw
      $error("rxc_screen: DW must lie in 5..16");
   end
   if (OUT_REG < 0 || OUT_REG > 1) begin : g_bad_outreg
      $error("rxc_screen: OUT_REG must be 0 or 1");
   end

   logic [NUM_PAIRS-1:0][DW-1:0] pause_arr;
   logic [NUM_PAIRS-1:0][DW-1:0] resume_arr;
   verdict_t                     verdict;

   assign pause_arr[0]  = pause_char_a;
   assign pause_arr[1]  = pause_char_b;
   assign resume_arr[0] = resume_char_a;
   assign resume_arr[1] = resume_char_b;

   rxc_classify #(.DW(DW)) u_classify (
      .rx_data_i      (rx_data),
      .pause_chars_i  (pause_arr),
      .resume_chars_i (resume_arr),
      .spc_char_i     (pause_char_b),
      .mode_i         (fc_mode),
      .spc_en_i       (spc_en),
      .verdict_o      (verdict)
   );

   rxc_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .vld_i        (rx_valid),
      .data_i       (rx_data),
      .verdict_i    (verdict),
      .irq_en_i     (spc_irq_en),
      .fifo_we_o    (fifo_we),
      .fifo_wdata_o (fifo_wdata),
      .xoff_irq_o   (xoff_irq),
      .spc_irq_o    (spc_irq)
   );

   rxc_flow_state u_flow (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (rx_valid && verdict.pause),
      .clr_i    (rx_valid && verdict.resume),
      .paused_o (tx_paused)
   );

   rxc_spc_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rx_valid && verdict.spc),
      .clr_i  (isr_read),
      .flag_o (spc_flag)
   );

   if (OUT_REG != 0) begin : g_reg_checks
      AST_SPC_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         spc_irq |-> spc_flag); // R8
      AST_PAUSE_LEVEL_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         xoff_irq |-> tx_paused); // R3
   end

endmodule

// File: tb/rxc_screen_tb_top.sv
`timescale 1ns/1ps
module rxc_screen_tb_top;

   localparam int DW = 8;
   localparam int NV = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [DW-1:0] pause_char_a = 8'h13;
   logic [DW-1:0] resume_char_a = 8'h11;
   logic [DW-1:0] pause_char_b = 8'h93;
   logic [DW-1:0] resume_char_b = 8'h91;
   logic [1:0]    fc_mode = 2'b00;
   logic          spc_en = 1'b0;
   logic          spc_irq_en = 1'b0;
   logic          isr_read = 1'b0;
   logic          fifo_we;
   logic [DW-1:0] fifo_wdata;
   logic          xoff_irq;
   logic          spc_irq;
   logic          spc_flag;
   logic          tx_paused;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rxc_screen #(.DW(DW), .OUT_REG(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .pause_char_a(pause_char_a), .resume_char_a(resume_char_a),
      .pause_char_b(pause_char_b), .resume_char_b(resume_char_b),
      .fc_mode(fc_mode), .spc_en(spc_en), .spc_irq_en(spc_irq_en),
      .isr_read(isr_read), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
      .xoff_irq(xoff_irq), .spc_irq(spc_irq), .spc_flag(spc_flag),
      .tx_paused(tx_paused)
   );

   // {mode[1:0], spc_en, irq_en, byte[7:0], we, xoff, spc_irq, paused, flag}
   localparam logic [16:0] VEC [0:NV-1] = '{
      {2'b00, 1'b0, 1'b0, 8'h13, 5'b10000},  // R2 off: pause byte stored
      {2'b10, 1'b0, 1'b0, 8'h13, 5'b01010},  // R3 pause A
      {2'b10, 1'b0, 1'b0, 8'h55, 5'b10010},  // R3 data while paused
      {2'b10, 1'b0, 1'b0, 8'h11, 5'b00000},  // R3 resume A
      {2'b01, 1'b0, 1'b0, 8'h93, 5'b01010},  // R4 pause B
      {2'b00, 1'b0, 1'b0, 8'h91, 5'b10010},  // R2 resume ignored when off
      {2'b01, 1'b0, 1'b0, 8'h91, 5'b00000},  // R4 resume B
      {2'b00, 1'b0, 1'b1, 8'h93, 5'b10000},  // R5 detect disabled
      {2'b00, 1'b1, 1'b0, 8'h93, 5'b10001},  // R6 R8 flag without irq
      {2'b00, 1'b1, 1'b1, 8'h93, 5'b10101},  // R8 irq enabled
      {2'b10, 1'b1, 1'b1, 8'h93, 5'b10101},  // R6 pair A independent
      {2'b01, 1'b1, 1'b1, 8'h93, 5'b01111},  // R7 dropped, both irqs
      {2'b01, 1'b1, 1'b0, 8'h93, 5'b01011},  // R7 no spc irq when disabled
      {2'b01, 1'b1, 1'b1, 8'h92, 5'b10010},  // R6 bit-0 mismatch
      {2'b10, 1'b1, 1'b1, 8'h13, 5'b01010},  // R3 pause again while paused
      {2'b10, 1'b0, 1'b0, 8'h11, 5'b00000},  // R3 resume
      {2'b11, 1'b0, 1'b0, 8'h13, 5'b10000}   // R2 mode 11 off
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [1:0] m, input logic se, input logic ie,
                         input logic [7:0] b, input logic rd);
      @(negedge clk);
      fc_mode = m; spc_en = se; spc_irq_en = ie; rx_data = b;
      rx_valid = 1'b1; isr_read = rd;
      @(negedge clk);
      rx_valid = 1'b0; isr_read = 1'b0;
   endtask

   task automatic clear_flag();
      isr_read = 1'b1;
      @(negedge clk);
      isr_read = 1'b0;
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk({fifo_we, xoff_irq, spc_irq, spc_flag, tx_paused} == 5'b0, "R1 in reset",
          {fifo_we, xoff_irq, spc_irq, spc_flag, tx_paused}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({fifo_we, xoff_irq, spc_irq, spc_flag, tx_paused} == 5'b0, "R1 after release",
          {fifo_we, xoff_irq, spc_irq, spc_flag, tx_paused}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [16:0] v;
         v = VEC[i];
         strobe(v[16:15], v[14], v[13], v[12:5], 1'b0);
         chk({fifo_we, xoff_irq, spc_irq, tx_paused, spc_flag} == v[4:0],
             $sformatf("R2-R8 table vector %0d", i),
             {fifo_we, xoff_irq, spc_irq, tx_paused, spc_flag}, v[4:0]);
         if (v[4])
            chk(fifo_wdata == v[12:5], "R10 write data", fifo_wdata, v[12:5]);
         clear_flag();
      end

      // R10 latency: nothing in the strobe cycle, pulse one cycle later, then gone
      @(negedge clk);
      fc_mode = 2'b00; spc_en = 1'b0; rx_data = 8'hA5; rx_valid = 1'b1;
      #1;
      chk(fifo_we == 1'b0, "R10 no write in strobe cycle", fifo_we, 0);
      @(negedge clk);
      rx_valid = 1'b0;
      chk(fifo_we == 1'b1 && fifo_wdata == 8'hA5, "R10 write next cycle",
          {fifo_we, fifo_wdata}, {1'b1, 8'hA5});
      @(negedge clk);
      chk(fifo_we == 1'b0, "R10 single-cycle pulse", fifo_we, 0);

      // R12 no strobe: a pause byte on the data lines does nothing
      fc_mode = 2'b10; spc_en = 1'b1; spc_irq_en = 1'b1; rx_data = 8'h13;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk({fifo_we, xoff_irq, spc_irq, tx_paused} == 4'b0, "R12 idle",
             {fifo_we, xoff_irq, spc_irq, tx_paused}, 0);
      end

      // R9 sticky flag
      strobe(2'b00, 1'b1, 1'b0, 8'h93, 1'b0);
      repeat (4) @(negedge clk);
      chk(spc_flag == 1'b1, "R9 flag held while unread", spc_flag, 1);
      clear_flag();
      chk(spc_flag == 1'b0, "R9 flag cleared by read", spc_flag, 0);
      strobe(2'b00, 1'b1, 1'b0, 8'h93, 1'b1);
      chk(spc_flag == 1'b1, "R9 hit beats simultaneous read", spc_flag, 1);
      clear_flag();

      // R11 equal pause and resume characters
      resume_char_a = 8'h13;
      strobe(2'b10, 1'b0, 1'b0, 8'h13, 1'b0);
      chk({fifo_we, xoff_irq, tx_paused} == 3'b011, "R11 pause priority",
          {fifo_we, xoff_irq, tx_paused}, 3'b011);
      resume_char_a = 8'h11;

      // R1 reset clears pause state at once
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(tx_paused == 1'b0, "R1 reset clears pause", tx_paused, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({fifo_we, xoff_irq, spc_irq, spc_flag, tx_paused} == 5'b0, "R1 after second reset",
          {fifo_we, xoff_irq, spc_irq, spc_flag, tx_paused}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule